// File: doc/BRIEF.md
# Prioritized Direct-Vector Interrupt Controller

This block is the maskable interrupt front end of a small 8-bit processor. It watches three direct restart request lines and one externally vectored request line. At every instruction boundary, signalled by a one-cycle completion pulse from the core, it selects the most urgent request that is both unmasked and globally enabled. It then hands the core a 16-bit branch target together with a take-interrupt pulse.

The highest direct line is edge-sensitive. A rising edge on it is remembered in a latch until the request is served or software discards it. The two lower direct lines are level-sensitive and are only seen if they are high in the boundary cycle. Each direct source branches to a fixed address and never produces an acknowledge. The external source ranks below all direct sources. Its service starts with a one-cycle active-low acknowledge. The vector byte that the requesting device drives during that cycle is scaled by eight to form the target address.

Software controls the block through a single configuration write port. The port holds the per-source mask bits, the global enable, and a discard bit for the edge latch. Taking any interrupt drops the global enable. Once firmware enables interrupts again, a lower-ranked request may interrupt a higher one's service routine.

Top module: `irq_vector_front`

## Requirements
- R1: After reset, `takeIrq` is 0 and `ackN` is 1. All direct sources are masked, the global enable is off and the edge latch is empty, so no request is taken at a boundary.
- R2: A rising edge on `reqEdge` is latched, even if the line falls again before the boundary. At the next enabled boundary it yields a take with target 0x003C.
- R3: `reqMid` yields target 0x0034 and `reqLow` yields target 0x002C. Each is taken only if it is high in the cycle `instrDone` is high. A level pulse that ends before that cycle leaves no request behind.
- R4: Among eligible requests the ranking is edge > mid > low > external.
- R5: `cfgWrData` bit 0 masks `reqLow`, bit 1 masks `reqMid` and bit 2 masks `reqEdge` (1 = masked). A masked source does not block a lower-ranked one. The external request has no mask of its own.
- R6: `cfgWrData` bit 3 sets the global enable, which gates all four sources. A take clears the enable, so a request still held afterwards is not taken until software sets the enable again.
- R7: A decision is made only in a cycle where `instrDone` is 1. For a direct source, `takeIrq` is high for exactly the following cycle, with `targetAddr` valid.
- R8: An external take drives `ackN` low for exactly the cycle after the boundary. `extVector` is sampled in that cycle, and `takeIrq` rises in the next cycle with `targetAddr` = `extVector` × 8. Direct takes never drive `ackN` low.
- R9: The edge latch is cleared when its request is taken, or by a configuration write with bit 4 set. A line held high after the take does not re-request without a new rising edge.
- R10: After a higher-ranked take, once software re-enables, a pending lower-ranked request is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqEdge | input | 1 | Edge-triggered direct request, top rank |
| reqMid | input | 1 | Level direct request, second rank |
| reqLow | input | 1 | Level direct request, third rank |
| reqExt | input | 1 | Externally vectored request, lowest rank |
| instrDone | input | 1 | Instruction-complete pulse from the core |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 5 | Masks [2:0], global enable [3], edge-latch discard [4] |
| extVector | input | 8 | Vector byte from the external device |
| takeIrq | output | 1 | One-cycle take-interrupt pulse |
| targetAddr | output | 16 | Branch target, valid with `takeIrq` |
| ackN | output | 1 | Active-low acknowledge for external requests |

## Verification
The bound checker enforces the timing rules on every cycle:
- a take only follows a boundary or an acknowledge cycle;
- the acknowledge lasts one cycle and is always followed by a take;
- no two takes occur back to back;
- a direct take lands on one of the three fixed addresses;
- an external take equals eight times the byte sampled during the acknowledge.

The remaining behaviours depend on the order of stimulus and are only shown by the bench scenarios:
- which source wins a given mix of requests and masks;
- that a level pulse dropped before the boundary is forgotten;
- that the edge latch clears by take or by software;
- that a lower request preempts a higher one only after re-enable.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NUM_DIRECT = 3;
  localparam int SRC_W = 2;
  localparam int ADDR_W = 16;
  localparam int EDGE_IDX = NUM_DIRECT - 1;
  localparam int CFG_EN_BIT = NUM_DIRECT;
  localparam int CFG_CLR_BIT = NUM_DIRECT + 1;
  localparam int CFG_W = NUM_DIRECT + 2;
  localparam logic [ADDR_W-1:0] DIRECT_BASE = 16'h002C;
  localparam logic [ADDR_W-1:0] DIRECT_STEP = 16'h0008;

  typedef enum logic {ST_IDLE, ST_ACK} ctrlState_t;

  typedef struct packed {
    logic             loadDirect;
    logic [SRC_W-1:0] srcSel;
    logic             loadExt;
    logic             clrEnable;
  } ctrlStrobes_t;

  // Direct source i branches to base + i*step: 0x2C, 0x34, 0x3C
  function automatic logic [ADDR_W-1:0] directVector(input logic [SRC_W-1:0] idx);
    return DIRECT_BASE + DIRECT_STEP * ADDR_W'(idx);
  endfunction
endpackage

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  instrDone,
  input  logic [NUM_DIRECT-1:0] directElig,
  input  logic                  extElig,
  output ctrlStrobes_t          strb,
  output logic                  ackN
);
  ctrlState_t state, nextState;
  logic found;

  always_comb begin
    strb = '0;
    nextState = state;
    found = 1'b0;
    if (state == ST_IDLE) begin
      if (instrDone) begin
        // highest index ranks first
        for (int i = NUM_DIRECT - 1; i >= 0; i--) begin
          if (!found && directElig[i]) begin
            found = 1'b1;
            strb.srcSel = SRC_W'(i);
          end
        end
        if (found) begin
          strb.loadDirect = 1'b1;
          strb.clrEnable = 1'b1;
        end else if (extElig) begin
          strb.clrEnable = 1'b1;
          nextState = ST_ACK;
        end
      end
    end else begin
      strb.loadExt = 1'b1;
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  assign ackN = (state != ST_ACK);
endmodule

// File: rtl/irq_vec_dp.sv
module irq_vec_dp
  import irq_vec_pkg::*;
#(
  parameter int EXT_VEC_W = 8,
  parameter int EXT_SHIFT = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqEdge,
  input  logic [EDGE_IDX-1:0]   reqLevel,
  input  logic                  reqExt,
  input  logic                  cfgWrEn,
  input  logic [CFG_W-1:0]      cfgWrData,
  input  logic [EXT_VEC_W-1:0]  extVector,
  input  ctrlStrobes_t          strb,
  output logic [NUM_DIRECT-1:0] directElig,
  output logic                  extElig,
  output logic                  takeIrq,
  output logic [ADDR_W-1:0]     targetAddr
);
  logic [NUM_DIRECT-1:0] maskBits;
  logic globalEn, edgeLatch, edgePrev, edgeRise, edgeClr;
  logic [NUM_DIRECT-1:0] rawDirect;

  assign edgeRise = reqEdge & ~edgePrev;
  assign edgeClr = (strb.loadDirect && strb.srcSel == SRC_W'(EDGE_IDX))
                 || (cfgWrEn && cfgWrData[CFG_CLR_BIT]);
  assign rawDirect = {edgeLatch, reqLevel};

  for (genvar g = 0; g < NUM_DIRECT; g++) begin : gElig
    assign directElig[g] = rawDirect[g] & ~maskBits[g] & globalEn;
  end
  assign extElig = reqExt & globalEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskBits <= '1;
      globalEn <= 1'b0;
      edgeLatch <= 1'b0;
      edgePrev <= 1'b1;
    end else begin
      edgePrev <= reqEdge;
      if (cfgWrEn) maskBits <= cfgWrData[NUM_DIRECT-1:0];
      if (strb.clrEnable) globalEn <= 1'b0;
      else if (cfgWrEn) globalEn <= cfgWrData[CFG_EN_BIT];
      if (edgeRise) edgeLatch <= 1'b1;
      else if (edgeClr) edgeLatch <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeIrq <= 1'b0;
      targetAddr <= '0;
    end else begin
      takeIrq <= strb.loadDirect | strb.loadExt;
      if (strb.loadDirect) targetAddr <= directVector(strb.srcSel);
      else if (strb.loadExt) targetAddr <= ADDR_W'(extVector) << EXT_SHIFT;
    end
  end
endmodule

// File: rtl/irq_vector_front.sv
module irq_vector_front
  import irq_vec_pkg::*;
#(
  parameter int EXT_VEC_W = 8,
  parameter int EXT_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqEdge,
  input  logic                 reqMid,
  input  logic                 reqLow,
  input  logic                 reqExt,
  input  logic                 instrDone,
  input  logic                 cfgWrEn,
  input  logic [CFG_W-1:0]     cfgWrData,
  input  logic [EXT_VEC_W-1:0] extVector,
  output logic                 takeIrq,
  output logic [ADDR_W-1:0]    targetAddr,
  output logic                 ackN
);
  ctrlStrobes_t strb;
  logic [NUM_DIRECT-1:0] directElig;
  logic extElig;

  irq_vec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .instrDone(instrDone),
    .directElig(directElig), .extElig(extElig),
    .strb(strb), .ackN(ackN)
  );

  irq_vec_dp #(.EXT_VEC_W(EXT_VEC_W), .EXT_SHIFT(EXT_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .reqEdge(reqEdge), .reqLevel({reqMid, reqLow}),
    .reqExt(reqExt), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .extVector(extVector), .strb(strb), .directElig(directElig),
    .extElig(extElig), .takeIrq(takeIrq), .targetAddr(targetAddr)
  );
endmodule

// File: rtl/irq_vec_checker.sv
module irq_vec_checker (
  input logic        clk,
  input logic        rstN,
  input logic        instrDone,
  input logic [7:0]  extVector,
  input logic        takeIrq,
  input logic [15:0] targetAddr,
  input logic        ackN
);
  // R7: a take follows a boundary or an acknowledge cycle
  a_r7_take_after_done: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ($past(instrDone) || !$past(ackN)));

  // R8: acknowledge is low for one cycle only
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |=> ackN);

  // R8: acknowledge starts right after a boundary
  a_r8_ack_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> $past(instrDone));

  // R8: acknowledge cycle is followed by the take
  a_r8_ext_take: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |=> takeIrq);

  // R8: external target is the sampled byte times eight
  a_r8_ext_addr: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && !$past(ackN)) |-> (targetAddr == (16'($past(extVector)) << 3)));

  // R2 R3: direct targets are one of the fixed addresses
  a_r3_direct_addr: assert property (@(posedge clk) disable iff (!rstN)
    (takeIrq && $past(ackN)) |->
      (targetAddr == 16'h002C || targetAddr == 16'h0034 || targetAddr == 16'h003C));

  // R6: a take drops the enable, so no take or acknowledge follows at once
  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> (!takeIrq && ackN));
endmodule

bind irq_vector_front irq_vec_checker u_chk (
  .clk(clk), .rstN(rstN), .instrDone(instrDone), .extVector(extVector),
  .takeIrq(takeIrq), .targetAddr(targetAddr), .ackN(ackN)
);

// File: tb/tb_irq_vector_front.sv
module tb_irq_vector_front;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] ENA = 5'b01000;

  logic clk = 0, rstN = 0;
  logic reqEdge = 0, reqMid = 0, reqLow = 0, reqExt = 0, instrDone = 0, cfgWrEn = 0;
  logic [4:0] cfgWrData = '0;
  logic [7:0] extVector = '0;
  logic takeIrq, ackN;
  logic [15:0] targetAddr;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_front dut (
    .clk(clk), .rstN(rstN), .reqEdge(reqEdge), .reqMid(reqMid), .reqLow(reqLow),
    .reqExt(reqExt), .instrDone(instrDone), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .extVector(extVector), .takeIrq(takeIrq), .targetAddr(targetAddr), .ackN(ackN)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [4:0] d);
    @(negedge clk); cfgWrEn = 1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 0; cfgWrData = '0;
  endtask

  task automatic pulseEdge();
    @(negedge clk); reqEdge = 1;
    @(negedge clk); reqEdge = 0;
  endtask

  task automatic doDone();
    @(negedge clk); instrDone = 1;
    @(negedge clk); instrDone = 0; #1;
  endtask

  task automatic expectDirect(input string req, input logic [15:0] addr);
    doDone();
    check({req, " take"}, takeIrq, 1);
    check({req, " addr"}, targetAddr, addr);
    check({req, " no ack (R8)"}, ackN, 1);
    @(negedge clk); #1;
    check({req, " one-cycle take (R7)"}, takeIrq, 0);
  endtask

  task automatic expectNone(input string req);
    doDone();
    check({req, " no take"}, takeIrq, 0);
    check({req, " no ack"}, ackN, 1);
  endtask

  task automatic expectExt(input string req, input logic [7:0] vec);
    extVector = vec;
    doDone();
    check({req, " ack low"}, ackN, 0);
    check({req, " no take during ack"}, takeIrq, 0);
    @(negedge clk); #1;
    check({req, " take after ack"}, takeIrq, 1);
    check({req, " ext addr"}, targetAddr, {5'b0, vec, 3'b0});
    check({req, " ack released"}, ackN, 1);
  endtask

  task automatic t_reset();
    #1;
    check("R1 take after reset", takeIrq, 0);
    check("R1 ack after reset", ackN, 1);
    reqMid = 1; reqLow = 1; reqExt = 1;
    expectNone("R1 reset masks/enable");
    reqMid = 0; reqLow = 0; reqExt = 0;
  endtask

  task automatic t_edge();
    cfg(ENA);
    pulseEdge();
    expectDirect("R2 edge latched", 16'h003C);
    cfg(ENA);
    expectNone("R9 latch cleared by take");
    @(negedge clk); reqEdge = 1;
    cfg(ENA);
    expectDirect("R2 edge held", 16'h003C);
    cfg(ENA);
    expectNone("R9 held line no re-request");
    reqEdge = 0;
  endtask

  task automatic t_level();
    cfg(ENA);
    reqMid = 1;
    repeat (3) @(negedge clk);
    #1 check("R7 no take without boundary", takeIrq, 0);
    expectDirect("R3 mid", 16'h0034);
    reqMid = 0;
    cfg(ENA);
    reqLow = 1;
    expectDirect("R3 low", 16'h002C);
    reqLow = 0;
    cfg(ENA);
    @(negedge clk); reqLow = 1;
    @(negedge clk); reqLow = 0;
    expectNone("R3 dropped level forgotten");
  endtask

  task automatic t_priority();
    reqMid = 1; reqLow = 1; reqExt = 1;
    pulseEdge();
    cfg(ENA);
    expectDirect("R4 edge first", 16'h003C);
    cfg(ENA);
    expectDirect("R4 mid over low", 16'h0034);
    reqMid = 0;
    cfg(ENA);
    expectDirect("R4 low over ext", 16'h002C);
    reqLow = 0;
    cfg(ENA);
    expectExt("R4 ext last", 8'h11);
    reqExt = 0;
  endtask

  task automatic t_mask();
    reqMid = 1; reqLow = 1;
    cfg(5'b01010);
    expectDirect("R5 masked mid skipped", 16'h002C);
    reqExt = 1;
    cfg(5'b01111);
    expectExt("R5 ext unmasked", 8'h3C);
    reqMid = 0; reqLow = 0; reqExt = 0;
  endtask

  task automatic t_ext();
    reqExt = 1;
    cfg(ENA);
    expectExt("R8 vector A5", 8'hA5);
    cfg(ENA);
    expectExt("R8 vector FF", 8'hFF);
    reqExt = 0;
  endtask

  task automatic t_global();
    reqMid = 1;
    cfg(ENA);
    expectDirect("R6 first take", 16'h0034);
    expectNone("R6 enable cleared by take");
    cfg(5'b00000);
    expectNone("R6 enable off gates all");
    reqMid = 0;
  endtask

  task automatic t_swclear();
    pulseEdge();
    cfg(5'b11000);
    expectNone("R9 software discard");
  endtask

  task automatic t_preempt();
    reqLow = 1;
    pulseEdge();
    cfg(ENA);
    expectDirect("R10 high first", 16'h003C);
    cfg(ENA);
    expectDirect("R10 lower preempts", 16'h002C);
    reqLow = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_edge();
    t_level();
    t_priority();
    t_mask();
    t_ext();
    t_global();
    t_swclear();
    t_preempt();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule